// File: doc/BRIEF.md
# Interleave-Aware Symmetric Horizontal FIR

This block filters a stream of 12-bit two's complement pixels along a line. It has eight multipliers. In symmetric mode a pre-adder folds pairs of taps that sit at equal distance from the centre, which gives a 16-tap response. In asymmetric mode the pre-adder's second operand is forced to zero, which gives an 8-tap response. The delay between adjacent taps is programmable from 1 to 16 accepted samples. When up to sixteen streams are interleaved sample by sample, each tap therefore sees only samples of its own stream.

A decimation accumulator adds the filter sums of D consecutive eligible samples, with D from 1 to 16. It emits one 32-bit result per group and then clears. This lets the same taps build a longer effective filter at a reduced output rate.

Coefficients are held in a store of 256 sets of eight. The set is picked per sample, and any single coefficient can be rewritten through a write port. A change of mode, tap spacing or decimation factor flushes the delay line. Outputs stay off until the line has refilled.

Top module: `hfir_core`

## Requirements
- R1: After reset, res_valid_o is low and res_o is zero. The active configuration is asymmetric, spacing 1, decimation 1, with all history and coefficients zero.
- R2: In symmetric mode (sym_i=1) each eligible sample x[t] yields the sum over i=0..7 of c[s][i]*(x[t-i*N] + x[t-(15-i)*N]). Arithmetic is signed, with 12-bit data and coefficients and a 32-bit result. A sample accepted at clock edge E gives res_valid_o high in the cycle after edge E+1.
- R3: In asymmetric mode (sym_i=0) taps 8..15 have no effect, and the sum is c[s][i]*x[t-i*N] over i=0..7.
- R4: Tap spacing N = ilv_i+1 (1..16) counts accepted samples. Interleaved streams are kept apart when N equals the number of streams.
- R5: With D = dec_i+1 (1..16), the sums of D consecutive eligible samples are added. One result is emitted per D eligible samples, and the accumulator then restarts from zero.
- R6: After reset or a flush, a sample is eligible only once the count of accepted samples reaches (T-1)*N+1, where T=16 in symmetric mode and T=8 in asymmetric mode. No result comes out before that.
- R7: A clock edge at which {sym_i, ilv_i, dec_i} differs from the active configuration adopts the new configuration. The same edge zeroes the history, restarts the fill count, drops any partial decimation group, and discards a sample presented in that cycle. A result already completed by the preceding sample is still emitted.
- R8: When cw_en_i is high, an edge writes cw_dat_i to coefficient cw_idx_i of set cw_set_i. Index i multiplies tap i, and in symmetric mode also tap 15-i. Other sets are unchanged. set_i selects the set used for the sample presented with it.
- R9: Cycles with pix_valid_i low neither shift the history nor produce a result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pix_i | input | 12 | Pixel sample, two's complement |
| pix_valid_i | input | 1 | Pixel sample present |
| set_i | input | 8 | Coefficient set for this sample |
| sym_i | input | 1 | 1 = symmetric 16-tap, 0 = asymmetric 8-tap |
| ilv_i | input | 4 | Tap spacing minus one |
| dec_i | input | 4 | Decimation factor minus one |
| cw_en_i | input | 1 | Coefficient write enable |
| cw_set_i | input | 8 | Set being written |
| cw_idx_i | input | 3 | Coefficient index within the set |
| cw_dat_i | input | 12 | Coefficient value, two's complement |
| res_o | output | 32 | Filter result, two's complement |
| res_valid_o | output | 1 | Result present |

## Verification
A wrong tap index or a misapplied spacing corrupts the very first eligible result after a flush, so it shows within (T-1)*N+1 accepted samples. A fill count that is off by one produces a result one sample early or late. The scoreboard sees this either as an output it did not expect or as an expectation left over at drain. A fault in the decimation counter or in the clearing of the accumulator changes the value or the spacing of results within one group of D samples. A coefficient written to the wrong set changes the results of the next stream that uses the disturbed set.

// File: rtl/hfir_pkg.sv
`timescale 1ns/1ps
package hfir_pkg;
  localparam int DATA_W  = 12;
  localparam int COEF_W  = 12;
  localparam int TAPS    = 16;
  localparam int MAX_ILV = 16;
  localparam int MAX_DEC = 16;
  localparam int N_SETS  = 256;
  localparam int OUT_W   = 32;

  localparam int NMUL     = TAPS / 2;
  localparam int ILV_W    = $clog2(MAX_ILV);
  localparam int DEC_W    = $clog2(MAX_DEC);
  localparam int SET_W    = $clog2(N_SETS);
  localparam int IDX_W    = $clog2(NMUL);
  localparam int HIST_LEN = (TAPS - 1) * MAX_ILV + 1;
  localparam int PRE_W    = DATA_W + 1;
  localparam int PROD_W   = PRE_W + COEF_W;
  localparam int SUM_W    = PROD_W + IDX_W;

  typedef struct packed {
    logic             sym;
    logic [ILV_W-1:0] ilv;
    logic [DEC_W-1:0] dec;
  } cfg_t;
endpackage

// File: rtl/hfir_coef_store.sv
`timescale 1ns/1ps
module hfir_coef_store import hfir_pkg::*; (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         we_i,
  input  logic [SET_W-1:0]             wset_i,
  input  logic [IDX_W-1:0]             widx_i,
  input  logic [COEF_W-1:0]            wdat_i,
  input  logic [SET_W-1:0]             rset_i,
  output logic [NMUL-1:0][COEF_W-1:0]  coef_o
);
  localparam int DEPTH = N_SETS * NMUL;
  localparam int AW    = SET_W + IDX_W;

  logic [COEF_W-1:0] mem_q [DEPTH];
  logic [AW-1:0]     waddr;

  assign waddr = {wset_i, widx_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int j = 0; j < DEPTH; j++) mem_q[j] <= '0;
    end else if (we_i) begin
      mem_q[waddr] <= wdat_i;
    end
  end

  for (genvar i = 0; i < NMUL; i++) begin : g_rd
    assign coef_o[i] = mem_q[{rset_i, IDX_W'(i)}];
  end

  assert_coef_write_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> mem_q[$past(waddr)] == $past(wdat_i));
endmodule

// File: rtl/hfir_delay_line.sv
`timescale 1ns/1ps
module hfir_delay_line import hfir_pkg::*; (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        vld_i,
  input  logic [DATA_W-1:0]           pix_i,
  input  cfg_t                        cfg_i,
  output cfg_t                        cfg_o,
  output logic                        flush_o,
  output logic                        smp_vld_o,
  output logic [TAPS-1:0][DATA_W-1:0] taps_o
);
  localparam int FILL_W = $clog2(HIST_LEN + 1);
  localparam int HW     = $clog2(HIST_LEN);

  logic [DATA_W-1:0] hist_q [HIST_LEN];
  logic [FILL_W-1:0] fill_q, fill_nx, span;
  cfg_t              cfg_q;
  logic              vld_q;

  assign flush_o   = (cfg_i != cfg_q);
  assign cfg_o     = cfg_q;
  assign smp_vld_o = vld_q;
  assign fill_nx   = fill_q + FILL_W'(1);

  // samples needed before the oldest used tap holds real data
  always_comb begin
    if (cfg_q.sym) span = FILL_W'((TAPS - 1) * (int'(cfg_q.ilv) + 1) + 1);
    else           span = FILL_W'((NMUL - 1) * (int'(cfg_q.ilv) + 1) + 1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int j = 0; j < HIST_LEN; j++) hist_q[j] <= '0;
      fill_q <= '0;
      vld_q  <= 1'b0;
      cfg_q  <= '0;
    end else if (flush_o) begin
      for (int j = 0; j < HIST_LEN; j++) hist_q[j] <= '0;
      fill_q <= '0;
      vld_q  <= 1'b0;
      cfg_q  <= cfg_i;
    end else begin
      vld_q <= vld_i && (fill_nx >= span);
      if (vld_i) begin
        hist_q[0] <= pix_i;
        for (int j = 1; j < HIST_LEN; j++) hist_q[j] <= hist_q[j-1];
        if (fill_q != span) fill_q <= fill_nx;
      end
    end
  end

  always_comb begin
    for (int k = 0; k < TAPS; k++) begin
      taps_o[k] = hist_q[HW'(k * (int'(cfg_q.ilv) + 1))];
    end
  end

  assert_fill_before_valid_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_q |-> fill_q == span);
endmodule

// File: rtl/hfir_mac.sv
`timescale 1ns/1ps
module hfir_mac import hfir_pkg::*; (
  input  logic                        sym_i,
  input  logic [TAPS-1:0][DATA_W-1:0] taps_i,
  input  logic [NMUL-1:0][COEF_W-1:0] coef_i,
  output logic signed [SUM_W-1:0]     sum_o
);
  logic signed [PROD_W-1:0] prod [NMUL];

  for (genvar i = 0; i < NMUL; i++) begin : g_mul
    logic signed [PRE_W-1:0] near, far, pre;
    assign near = {taps_i[i][DATA_W-1], taps_i[i]};
    // asymmetric mode: mirrored operand forced to zero
    assign far  = sym_i ? {taps_i[TAPS-1-i][DATA_W-1], taps_i[TAPS-1-i]} : '0;
    assign pre  = near + far;
    assign prod[i] = pre * $signed(coef_i[i]);
  end

  always_comb begin
    sum_o = '0;
    for (int i = 0; i < NMUL; i++) sum_o = sum_o + SUM_W'(prod[i]);
  end
endmodule

// File: rtl/hfir_dec_acc.sv
`timescale 1ns/1ps
module hfir_dec_acc import hfir_pkg::*; (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    smp_vld_i,
  input  logic                    flush_i,
  input  logic [DEC_W-1:0]        dec_i,
  input  logic signed [SUM_W-1:0] sum_i,
  output logic [OUT_W-1:0]        res_o,
  output logic                    res_vld_o
);
  logic signed [OUT_W-1:0] acc_q, tot;
  logic [DEC_W-1:0]        dcnt_q;

  assign tot = (dcnt_q == '0 ? '0 : acc_q) + OUT_W'(sum_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q     <= '0;
      dcnt_q    <= '0;
      res_o     <= '0;
      res_vld_o <= 1'b0;
    end else begin
      res_vld_o <= 1'b0;
      if (smp_vld_i) begin
        if (dcnt_q == dec_i) begin
          res_o     <= tot;
          res_vld_o <= 1'b1;
          dcnt_q    <= '0;
        end else begin
          acc_q  <= tot;
          dcnt_q <= dcnt_q + DEC_W'(1);
        end
      end
      // partial group is dropped; a completed result above still leaves
      if (flush_i) begin
        acc_q  <= '0;
        dcnt_q <= '0;
      end
    end
  end

  assert_dcnt_range_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dcnt_q <= dec_i);
endmodule

// File: rtl/hfir_core.sv
`timescale 1ns/1ps
module hfir_core import hfir_pkg::*; (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] pix_i,
  input  logic              pix_valid_i,
  input  logic [SET_W-1:0]  set_i,
  input  logic              sym_i,
  input  logic [ILV_W-1:0]  ilv_i,
  input  logic [DEC_W-1:0]  dec_i,
  input  logic              cw_en_i,
  input  logic [SET_W-1:0]  cw_set_i,
  input  logic [IDX_W-1:0]  cw_idx_i,
  input  logic [COEF_W-1:0] cw_dat_i,
  output logic [OUT_W-1:0]  res_o,
  output logic              res_valid_o
);
  cfg_t                        cfg_in, cfg_act;
  logic                        flush, smp_vld;
  logic [TAPS-1:0][DATA_W-1:0] taps;
  logic [NMUL-1:0][COEF_W-1:0] coef;
  logic signed [SUM_W-1:0]     sum;
  logic [SET_W-1:0]            set_q;

  assign cfg_in = '{sym: sym_i, ilv: ilv_i, dec: dec_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          set_q <= '0;
    else if (pix_valid_i) set_q <= set_i;
  end

  hfir_delay_line u_line (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .vld_i     (pix_valid_i),
    .pix_i     (pix_i),
    .cfg_i     (cfg_in),
    .cfg_o     (cfg_act),
    .flush_o   (flush),
    .smp_vld_o (smp_vld),
    .taps_o    (taps)
  );

  hfir_coef_store u_coef (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (cw_en_i),
    .wset_i (cw_set_i),
    .widx_i (cw_idx_i),
    .wdat_i (cw_dat_i),
    .rset_i (set_q),
    .coef_o (coef)
  );

  hfir_mac u_mac (
    .sym_i  (cfg_act.sym),
    .taps_i (taps),
    .coef_i (coef),
    .sum_o  (sum)
  );

  hfir_dec_acc u_acc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .smp_vld_i (smp_vld),
    .flush_i   (flush),
    .dec_i     (cfg_act.dec),
    .sum_i     (sum),
    .res_o     (res_o),
    .res_vld_o (res_valid_o)
  );

  assert_res_after_sample_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> $past(smp_vld));

  assert_flush_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush |=> ##1 !res_valid_o);
endmodule

// File: tb/hfir_core_tb.sv
`timescale 1ns/1ps
module hfir_core_tb;
  import hfir_pkg::*;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic [DATA_W-1:0] pix_i = '0;
  logic              pix_valid_i = 1'b0;
  logic [SET_W-1:0]  set_i = '0;
  logic              sym_i = 1'b0;
  logic [ILV_W-1:0]  ilv_i = '0;
  logic [DEC_W-1:0]  dec_i = '0;
  logic              cw_en_i = 1'b0;
  logic [SET_W-1:0]  cw_set_i = '0;
  logic [IDX_W-1:0]  cw_idx_i = '0;
  logic [COEF_W-1:0] cw_dat_i = '0;
  logic [OUT_W-1:0]  res_o;
  logic              res_valid_o;

  always #2.5 clk_i = ~clk_i;

  hfir_core u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .pix_i(pix_i), .pix_valid_i(pix_valid_i),
    .set_i(set_i), .sym_i(sym_i), .ilv_i(ilv_i), .dec_i(dec_i),
    .cw_en_i(cw_en_i), .cw_set_i(cw_set_i), .cw_idx_i(cw_idx_i), .cw_dat_i(cw_dat_i),
    .res_o(res_o), .res_valid_o(res_valid_o)
  );

  typedef struct {
    logic [31:0] val;
    string       tag;
  } exp_t;

  exp_t        q[$];
  int          n_chk = 0, n_bad = 0, n_out = 0;
  bit          done = 1'b0;
  string       tag = "R1";
  int unsigned seed = 32'h1234_5678;

  // reference model state
  int     hist[HIST_LEN];
  int     fill = 0, dcnt = 0, mn = 1, md = 1;
  longint acc = 0;
  bit     msym = 1'b0;
  int     cf[N_SETS][NMUL];

  function automatic int rnd();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return int'((seed >> 20) & 32'hFFF) - 2048;
  endfunction

  function automatic void check(bit ok, string t, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", t, act, exp);
    end
  endfunction

  function automatic void model_clear();
    for (int j = 0; j < HIST_LEN; j++) hist[j] = 0;
    fill = 0; dcnt = 0; acc = 0;
  endfunction

  task automatic idle(int n);
    pix_valid_i = 1'b0;
    repeat (n) @(negedge clk_i);
  endtask

  task automatic wcoef(int s, int i, int v);
    cw_en_i = 1'b1; cw_set_i = SET_W'(s); cw_idx_i = IDX_W'(i); cw_dat_i = COEF_W'(v);
    cf[s][i] = v;
    @(negedge clk_i);
    cw_en_i = 1'b0;
  endtask

  task automatic px(int x, int s);
    int     span;
    longint sum, tot;
    pix_i = DATA_W'(x); set_i = SET_W'(s); pix_valid_i = 1'b1;
    for (int j = HIST_LEN - 1; j > 0; j--) hist[j] = hist[j-1];
    hist[0] = x;
    span = msym ? 15 * mn + 1 : 7 * mn + 1;
    if (fill < span) fill++;
    if (fill >= span) begin
      sum = 0;
      for (int i = 0; i < NMUL; i++)
        sum += longint'(cf[s][i]) * (hist[i*mn] + (msym ? hist[(15-i)*mn] : 0));
      tot = (dcnt == 0 ? 0 : acc) + sum;
      if (dcnt == md - 1) begin
        q.push_back('{tot[31:0], tag});
        dcnt = 0;
      end else begin
        acc = tot;
        dcnt++;
      end
    end
    @(negedge clk_i);
    pix_valid_i = 1'b0;
  endtask

  task automatic set_cfg(bit s, int n, int d, bit with_px = 1'b0, int x = 0);
    sym_i = s; ilv_i = ILV_W'(n - 1); dec_i = DEC_W'(d - 1);
    if (with_px) begin pix_valid_i = 1'b1; pix_i = DATA_W'(x); end
    if (s != msym || n != mn || d != md) begin
      msym = s; mn = n; md = d;
      model_clear();
    end
    @(negedge clk_i);
    pix_valid_i = 1'b0;
  endtask

  task automatic stream(int n, int s0, int nsets);
    for (int k = 0; k < n; k++) px(rnd(), s0 + (k % nsets));
  endtask

  // scoreboard monitor
  always @(negedge clk_i) begin
    if (rst_ni && res_valid_o && !done) begin
      n_out++;
      if (q.size() == 0) begin
        n_chk++; n_bad++;
        $display("FAIL %s unexpected output actual=%0h expected=no output", tag, res_o);
      end else begin
        exp_t e;
        e = q.pop_front();
        check(res_o == e.val, e.tag, longint'(res_o), longint'(e.val));
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL %s watchdog actual=timeout expected=completion", tag);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int base;
    for (int s = 0; s < N_SETS; s++) for (int i = 0; i < NMUL; i++) cf[s][i] = 0;
    model_clear();
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    tag = "R1";
    check(res_valid_o == 1'b0, "R1 valid", longint'(res_valid_o), 0);
    check(res_o == '0, "R1 data", longint'(res_o), 0);

    // R8: coefficient loading
    tag = "R8";
    for (int s = 0; s < 3; s++)
      for (int i = 0; i < NMUL; i++)
        wcoef(s, i, ((s * 811 + i * 1237 + 97) % 4096) - 2048);
    for (int i = 0; i < NMUL; i++) wcoef(3, i, -2048);

    // R3: asymmetric, spacing 1
    tag = "R3";
    set_cfg(1'b0, 1, 1);
    stream(40, 0, 1);
    idle(3);

    // R2: symmetric, spacing 1
    tag = "R2";
    set_cfg(1'b1, 1, 1);
    stream(50, 1, 1);
    idle(3);

    // R4: three interleaved streams, set switches per sample
    tag = "R4";
    set_cfg(1'b1, 3, 1);
    stream(120, 0, 3);
    idle(3);

    // R6: widest asymmetric span, no output before fill completes
    tag = "R6";
    set_cfg(1'b0, 16, 1);
    base = n_out;
    stream(112, 2, 1);
    idle(4);
    check(n_out == base, "R6 no early output", longint'(n_out - base), 0);
    tag = "R4";
    stream(30, 2, 1);
    idle(3);

    // R5: maximum decimation
    tag = "R5";
    set_cfg(1'b1, 1, 16);
    stream(80, 0, 1);
    idle(3);

    // R9: gaps in the sample stream
    tag = "R9";
    set_cfg(1'b1, 3, 4);
    for (int k = 0; k < 120; k++) begin
      px(rnd(), k % 3);
      idle(k % 3);
    end
    idle(3);

    // R2: extreme operands
    tag = "R2";
    set_cfg(1'b1, 2, 2);
    for (int k = 0; k < 40; k++) px(-2048, 3);
    for (int k = 0; k < 40; k++) px(2047, 3);
    idle(3);

    // R7: flush mid group, sample on the change cycle is dropped
    tag = "R7";
    set_cfg(1'b0, 2, 3);
    stream(30, 1, 1);
    set_cfg(1'b1, 2, 3, 1'b1, 1234);
    stream(45, 1, 1);
    idle(3);

    // R8: rewrite other sets while streaming set 1, then use them
    tag = "R8";
    set_cfg(1'b1, 1, 1);
    for (int k = 0; k < 24; k++) begin
      cw_en_i = 1'b1; cw_set_i = SET_W'(k % 2 == 0 ? 0 : 2); cw_idx_i = IDX_W'(k % 8);
      cw_dat_i = COEF_W'(k * 150 - 1700);
      cf[k % 2 == 0 ? 0 : 2][k % 8] = k * 150 - 1700;
      px(rnd(), 1);
      cw_en_i = 1'b0;
    end
    idle(3);
    stream(30, 0, 1);
    stream(20, 2, 1);

    idle(10);
    check(q.size() == 0, "R5 drain", longint'(q.size()), 0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule